// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter advanced by a single-cycle tick taken from a free-running 17-bit divider of the system clock. A 3-bit select picks one of eight divide ratios. The counter overflows when it wraps from 0xFF to 0x00. What happens on overflow depends on a mode bit. In interval mode the block pulses an interrupt request, which suits periodic work. In watchdog mode it pulses an overflow output, latches a sticky overflow flag and, if enabled, pulses a reset request. That request comes with a type bit that tells a separate reset generator which style of reset to apply.

Software uses a single-cycle register port with three registers, chosen by a 2-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | Timer control | mode, enable, rate select |
| 1 | Count | the counter, readable and writable |
| 2 | Reset control | overflow flag, reset enable, reset type |

Writes take effect at the next clock edge. Read data is registered and is valid in the cycle after the read strobe. Clearing the flag uses a read-then-write-zero handshake, so a flag that software has never seen cannot be lost.

Top module: `guard_timer`

## Requirements
- R1: After reset, timer control reads 0x18, the count reads 0x00, reset control reads 0x1F, and irq_o, wdt_ovf_o, rst_req_o and rst_type_o are all 0.
- R2: Rate select codes 0 to 7 set the tick to the clock divided by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. The divider clears on reset and then runs freely. Consecutive overflows are therefore 256 × divisor cycles apart.
- R3: While the enable bit (timer control bit 5) is 0, the count is forced to 0x00 and held there, count writes are ignored, and no overflow occurs.
- R4: With the mode bit (timer control bit 6) at 0, every overflow gives a one-cycle irq_o pulse. In that mode wdt_ovf_o stays 0 and the overflow flag is left unchanged.
- R5: With the mode bit at 1, every overflow gives a one-cycle wdt_ovf_o pulse and sets the flag (reset control bit 7). In that mode irq_o stays 0.
- R6: Timer control bit 7 reads 0 and bits 4:3 read 1. Reset control bits 4:0 read 1. Writes to any of these reserved bits are ignored.
- R7: Writing 1 to the flag has no effect. Writing 0 clears the flag only if the flag has been read as 1 since it was last set.
- R8: When an overflow in watchdog mode and a valid clearing write fall in the same cycle, the flag stays set.
- R9: When reset enable (reset control bit 6) is 1, each watchdog overflow also gives a one-cycle rst_req_o pulse, coincident with wdt_ovf_o. When reset enable is 0, no pulse is given. rst_type_o always shows reset control bit 5, where 0 means power-on style and 1 means manual style.
- R10: A count write loads the written value at the next edge, and a tick in the same cycle is discarded. After loading 0xFF, the next tick produces an overflow.
- R11: Read data appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 timer control, 1 count, 2 reset control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interval overflow pulse |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |
| rst_req_o | output | 1 | Reset request pulse |
| rst_type_o | output | 1 | Requested reset style |

## Verification
The divider ratios are checked by measuring the cycles between successive interrupt pulses at three select codes. Because the ratios are not evenly spaced, a wrong tap shows up as a wrong period rather than a merely shifted one.

Overflow behaviour is tried in both modes and with reset enable on and off, which separates the interrupt path, the flag path and the reset-request path. Flag clearing is tried three ways: without a prior read, with a write of one, and after a read. A counter preload is timed so that a clearing write lands exactly on an overflow edge, which shows whether set or clear wins.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int ADDR_W   = 2;

  // field positions in the control registers
  localparam int MODE_BIT = 6;
  localparam int EN_BIT   = 5;
  localparam int FLAG_BIT = 7;
  localparam int RSTE_BIT = 6;
  localparam int RSTS_BIT = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_RSTC  = 2'd2
  } reg_sel_e;

  // divider bit whose rising edge gives the tick for each select code
  function automatic int tap_bit(input int code);
    case (code)
      0:       return 0;
      1:       return 5;
      2:       return 6;
      3:       return 8;
      4:       return 10;
      5:       return 12;
      6:       return 14;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler
  import guard_timer_pkg::*;
#(
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] tap_tick;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // a tap fires when its bit is set and every lower bit is clear,
  // i.e. in the cycle right after that bit rose
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int B = tap_bit(g);
    localparam logic [PRE_W-1:0] LOW_MASK = PRE_W'((64'd1 << B) - 64'd1);
    assign tap_tick[g] = div_q[B] && ((div_q & LOW_MASK) == '0);
  end

  assign tick_o = tap_tick[sel_i];
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)  cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && tick_i && !load_i && (cnt_q == '1);
endmodule

// File: rtl/gt_status.sv
module gt_status
  import guard_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_event_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              flag_o,
  output logic              rst_en_o,
  output logic              rst_sel_o
);
  logic flag_q, seen_q, rst_en_q, rst_sel_q;
  logic clear_ok, flag_d;

  assign clear_ok = wr_i && !wdata_i[FLAG_BIT] && seen_q;
  assign flag_d   = wd_event_i || (flag_q && !clear_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      seen_q    <= 1'b0;
      rst_en_q  <= 1'b0;
      rst_sel_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= flag_d && (seen_q || (rd_i && flag_q));
      if (wr_i) begin
        rst_en_q  <= wdata_i[RSTE_BIT];
        rst_sel_q <= wdata_i[RSTS_BIT];
      end
    end
  end

  assign flag_o    = flag_q;
  assign rst_en_o  = rst_en_q;
  assign rst_sel_o = rst_sel_q;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int PRE_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_ovf_o,
  output logic              rst_req_o,
  output logic              rst_type_o
);
  logic             mode_q, en_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick, wrap, cnt_load;
  logic [DATA_W-1:0] cnt_val;
  logic             stat_flag, stat_rst_en, stat_rst_sel;
  logic             wr_ctrl, wr_cnt, wr_rstc, rd_rstc;
  logic             irq_q, ovf_q, rreq_q;
  logic [DATA_W-1:0] rdata_q;

  assign wr_ctrl  = wr_en_i && (addr_i == REG_CTRL);
  assign wr_cnt   = wr_en_i && (addr_i == REG_COUNT);
  assign wr_rstc  = wr_en_i && (addr_i == REG_RSTC);
  assign rd_rstc  = rd_en_i && (addr_i == REG_RSTC);
  assign cnt_load = wr_cnt && en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= wdata_i[MODE_BIT];
      en_q   <= wdata_i[EN_BIT];
      sel_q  <= wdata_i[SEL_W-1:0];
    end
  end

  gt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  gt_counter #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_q),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_val),
    .wrap_o     (wrap)
  );

  gt_status u_stat (
    .clk        (clk),
    .rst        (rst),
    .wd_event_i (wrap && mode_q),
    .wr_i       (wr_rstc),
    .rd_i       (rd_rstc),
    .wdata_i    (wdata_i),
    .flag_o     (stat_flag),
    .rst_en_o   (stat_rst_en),
    .rst_sel_o  (stat_rst_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= wrap && !mode_q;
      ovf_q  <= wrap && mode_q;
      rreq_q <= wrap && mode_q && stat_rst_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        REG_CTRL:  rdata_q <= {1'b0, mode_q, en_q, 2'b11, sel_q};
        REG_COUNT: rdata_q <= cnt_val;
        REG_RSTC:  rdata_q <= {stat_flag, stat_rst_en, stat_rst_sel, 5'b11111};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o    = rdata_q;
  assign irq_o      = irq_q;
  assign wdt_ovf_o  = ovf_q;
  assign rst_req_o  = rreq_q;
  assign rst_type_o = stat_rst_sel;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_q,
  input logic       cnt_load,
  input logic [7:0] cnt_val,
  input logic       stat_flag,
  input logic       rd_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       wdt_ovf_o,
  input logic       rst_req_o
);
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (cnt_val == 8'h00)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(cnt_load) && (cnt_val != $past(cnt_val)))
      |-> (cnt_val == $past(cnt_val) + 8'd1)); // R2
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !wdt_ovf_o); // R4
  AST_WDT_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf_o |=> !wdt_ovf_o); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R4
  AST_FLAG_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf_o |-> stat_flag); // R8
  AST_REQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> wdt_ovf_o); // R9
  AST_CTRL_RSV: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == 2'd0) |=> (rdata_o[4:3] == 2'b11 && !rdata_o[7])); // R6
  AST_RSTC_RSV: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == 2'd2) |=> (rdata_o[4:0] == 5'b11111)); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en_i) |-> $stable(rdata_o)); // R11
endmodule

bind guard_timer guard_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .cnt_load  (cnt_load),
  .cnt_val   (cnt_val),
  .stat_flag (stat_flag),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .wdt_ovf_o (wdt_ovf_o),
  .rst_req_o (rst_req_o)
);

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, wdt_ovf_o, rst_req_o, rst_type_o;

  int n_checks = 0, n_fail = 0;
  int pcyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // mirror of the free-running divider count
  always @(posedge clk) begin
    if (rst) pcyc <= 0;
    else     pcyc <= pcyc + 1;
  end

  guard_timer u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o), .rst_req_o(rst_req_o),
    .rst_type_o(rst_type_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  // which: 0 irq_o, 1 wdt_ovf_o; n = cycles waited or -1
  task automatic wait_evt(input int which, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if ((which == 0 && irq_o) || (which == 1 && wdt_ovf_o)) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", irq_o, 0);
    check("R1 wdt_ovf", wdt_ovf_o, 0);
    check("R1 rst_req", rst_req_o, 0);
    check("R1 rst_type", rst_type_o, 0);
    do_read(2'd0, d); check("R1 ctrl", d, 8'h18);
    do_read(2'd1, d); check("R1 count", d, 8'h00);
    do_read(2'd2, d); check("R1 rstc", d, 8'h1F);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    do_write(2'd0, 8'hFF); do_read(2'd0, d); check("R6 ctrl all ones", d, 8'h7F);
    do_write(2'd0, 8'h00); do_read(2'd0, d); check("R6 ctrl zeros", d, 8'h18);
    do_write(2'd2, 8'h1F); do_read(2'd2, d); check("R6 rstc low bits", d, 8'h1F);
    do_write(2'd2, 8'h60); do_read(2'd2, d); check("R6 rstc upper", d, 8'h7F);
    do_write(2'd2, 8'h00); do_read(2'd2, d); check("R6 rstc cleared", d, 8'h1F);
  endtask

  task automatic t_load;
    logic [7:0] d;
    int n;
    do_write(2'd0, 8'h27);
    do_write(2'd1, 8'h80);
    do_read(2'd1, d); check("R10 load value", d, 8'h80);
    repeat (3) @(negedge clk);
    check("R11 read data held", rdata_o, 8'h80);
    do_write(2'd0, 8'h20);
    do_write(2'd1, 8'hFF);
    wait_evt(0, 4, n);
    check("R10 overflow right after FF load", (n > 0), 1);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    int n;
    do_write(2'd0, 8'h20);
    do_write(2'd1, 8'h40);
    do_write(2'd0, 8'h00);
    do_read(2'd1, d); check("R3 forced zero", d, 8'h00);
    do_write(2'd1, 8'h55);
    do_read(2'd1, d); check("R3 write ignored", d, 8'h00);
    wait_evt(0, 600, n); check("R3 no irq", n, -1);
    do_read(2'd1, d); check("R3 still zero", d, 8'h00);
  endtask

  task automatic t_interval_rates;
    logic [7:0] d;
    int n;
    do_write(2'd0, 8'h20);
    wait_evt(0, 1200, n);
    check("R4 wdt quiet at irq", wdt_ovf_o, 0);
    @(negedge clk); check("R4 irq one cycle", irq_o, 0);
    do_read(2'd2, d); check("R4 flag untouched", d, 8'h1F);
    wait_evt(0, 1200, n);
    wait_evt(0, 1200, n); check("R2 period div2", n, 512);
    do_write(2'd0, 8'h21);
    wait_evt(0, 40000, n);
    wait_evt(0, 40000, n); check("R2 period div64", n, 16384);
    do_write(2'd0, 8'h22);
    wait_evt(0, 70000, n);
    wait_evt(0, 70000, n); check("R2 period div128", n, 32768);
  endtask

  task automatic t_watchdog;
    logic [7:0] d;
    int n;
    do_write(2'd0, 8'h60);
    wait_evt(1, 1200, n);
    check("R5 wdt pulse seen", (n > 0), 1);
    check("R5 irq quiet", irq_o, 0);
    @(negedge clk); check("R5 wdt one cycle", wdt_ovf_o, 0);
    do_write(2'd0, 8'h40);
    do_write(2'd2, 8'h00);
    do_read(2'd2, d); check("R7 clear without read ignored", d, 8'h9F);
    do_write(2'd2, 8'h80);
    do_read(2'd2, d); check("R7 write one no effect", d, 8'h9F);
    do_write(2'd2, 8'h00);
    do_read(2'd2, d); check("R7 clear after read", d, 8'h1F);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    int n;
    do_write(2'd0, 8'h60);
    wait_evt(1, 1200, n);
    do_read(2'd2, d); check("R8 flag set before race", d, 8'h9F);
    @(negedge clk);
    while (pcyc % 2 != 0) @(negedge clk);
    wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 8'hFF;
    @(negedge clk);
    addr_i = 2'd2; wdata_i = 8'h00;
    @(negedge clk);
    wr_en_i = 1'b0;
    check("R8 overflow on clear edge", wdt_ovf_o, 1);
    do_read(2'd2, d); check("R8 set beats clear", d, 8'h9F);
  endtask

  task automatic t_reset_req;
    int n;
    do_write(2'd2, 8'h60);
    check("R9 type shows manual", rst_type_o, 1);
    wait_evt(1, 1200, n);
    check("R9 request with overflow", rst_req_o, 1);
    @(negedge clk); check("R9 request one cycle", rst_req_o, 0);
    do_write(2'd2, 8'h00);
    check("R9 type shows power-on", rst_type_o, 0);
    wait_evt(1, 1200, n);
    check("R9 overflow seen", (n > 0), 1);
    check("R9 no request when disabled", rst_req_o, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reserved();
    t_load();
    t_disable();
    t_interval_rates();
    t_watchdog();
    t_set_wins();
    t_reset_req();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule